// File: doc/BRIEF.md
# GPIO Bank Event Detector

This block watches one bank of input pins that are already synchronous to the clock and turns selected pin activity into latched event flags and one interrupt line. Each pin can be armed independently for a rising edge, a falling edge, a high level or a low level. Arming both edge conditions on one pin gives detection of either edge.

Software reaches the block through a small register port: an address, a write strobe, write data and combinational read data. Four arming registers, one per condition, are plain read/write words. Because they read back, one pin can be changed with a read-modify-write without disturbing the others. A fifth word holds the event flags and is cleared by writing ones.

An edge flag stays set until software clears it. A level flag is set again on every cycle that the pin stays at its armed level. Clearing it therefore only sticks once the pin has left that level. The interrupt is high whenever any flag is set.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, all four arming registers, the event flags and the interrupt are zero.
- R2: Register selection uses addr_i. 0 is rising arm, 1 is falling arm, 2 is high-level arm and 3 is low-level arm. A write replaces the whole word, and the word reads back on rdata_o in the same cycle addr_i selects it.
- R3: A pin whose rising-arm bit is 1 sets its flag at the first clock edge where it is sampled at 1 after a sample at 0. The flag remains set after the pin returns low.
- R4: A pin whose falling-arm bit is 1 sets its flag at the first clock edge where it is sampled at 0 after a sample at 1. The flag is not set by a rise.
- R5: A pin with both edge-arm bits set flags on a rise and again on a fall.
- R6: A pin armed for high level has its flag set again on every cycle it is 1, so a clear while the pin is high has no lasting effect. The flag remains set after the pin falls, until it is cleared.
- R7: A pin armed for low level behaves like R6 with the pin level inverted.
- R8: Address 4 reads the event flags. Writing there clears exactly the flags whose write-data bit is 1.
- R9: When an event and a clear of the same flag meet in one cycle, the flag ends set.
- R10: irq_o is 1 exactly when at least one flag is set.
- R11: A pin armed for no condition never sets its flag. Writes to addresses 5 to 7 change nothing, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NPINS | Synchronised pin levels |
| addr_i | input | 3 | Register select |
| wdata_i | input | NPINS | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | NPINS | Read data for the selected register |
| irq_o | output | 1 | Bank interrupt |

## Verification
The assertions take pins_i as already synchronous to clk_i and stable around the sampling edge. They take a write as lasting one cycle with a settled address and data. The bench meets this by changing pins, address, strobe and data only on falling clock edges and by holding the strobe for exactly one cycle. Level arming is written only while the armed pins sit away from the armed level, so no flag appears before the test that expects it.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_COND = 4;
  // index into the arming array equals the register address
  typedef enum logic [ADDR_W-1:0] {
    SEL_RISE = 3'd0,
    SEL_FALL = 3'd1,
    SEL_HIGH = 3'd2,
    SEL_LOW  = 3'd3,
    SEL_STAT = 3'd4
  } sel_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NPINS-1:0]                wdata_i,
  output logic [N_COND-1:0][NPINS-1:0]    arm_o
);
  for (genvar k = 0; k < N_COND; k++) begin : g_arm
    logic [NPINS-1:0] arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    arm_q <= '0;
      else if (we_i && addr_i == ADDR_W'(k))          arm_q <= wdata_i;
    end
    assign arm_o[k] = arm_q;
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NPINS-1:0]              pins_i,
  input  logic [N_COND-1:0][NPINS-1:0]  arm_i,
  output logic [NPINS-1:0]              evt_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  logic [NPINS-1:0] rise_hit, fall_hit, high_hit, low_hit;
  assign rise_hit = pins_i & ~prev_q & arm_i[SEL_RISE];
  assign fall_hit = ~pins_i & prev_q & arm_i[SEL_FALL];
  assign high_hit = pins_i & arm_i[SEL_HIGH];
  assign low_hit  = ~pins_i & arm_i[SEL_LOW];
  assign evt_o    = rise_hit | fall_hit | high_hit | low_hit;
endmodule

// File: rtl/evt_status.sv
module evt_status
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NPINS-1:0]   wdata_i,
  input  logic [NPINS-1:0]   evt_i,
  output logic [NPINS-1:0]   status_o
);
  logic [NPINS-1:0] status_q, clr_mask;

  assign clr_mask = (we_i && addr_i == SEL_STAT) ? wdata_i : '0;

  // set after clear: a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_mask) | evt_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPINS-1:0]    pins_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NPINS-1:0]    wdata_i,
  input  logic                we_i,
  output logic [NPINS-1:0]    rdata_o,
  output logic                irq_o
);
  logic [N_COND-1:0][NPINS-1:0] arm;
  logic [NPINS-1:0]             evt_vec, status_q, en_any;

  evt_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .arm_o(arm)
  );

  evt_detect #(.NPINS(NPINS)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .arm_i(arm),
    .evt_o(evt_vec)
  );

  evt_status #(.NPINS(NPINS)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .evt_i(evt_vec), .status_o(status_q)
  );

  assign en_any = arm[SEL_RISE] | arm[SEL_FALL] | arm[SEL_HIGH] | arm[SEL_LOW];

  always_comb begin
    case (addr_i)
      SEL_RISE: rdata_o = arm[SEL_RISE];
      SEL_FALL: rdata_o = arm[SEL_FALL];
      SEL_HIGH: rdata_o = arm[SEL_HIGH];
      SEL_LOW:  rdata_o = arm[SEL_LOW];
      SEL_STAT: rdata_o = status_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |status_q;
endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NPINS-1:0]   wdata_i,
  input logic               irq_o,
  input logic [NPINS-1:0]   status_q,
  input logic [NPINS-1:0]   evt_vec,
  input logic [NPINS-1:0]   en_any
);
  logic stat_wr;
  assign stat_wr = we_i && addr_i == SEL_STAT;

  // R3: flags never drop without a write to the flag word
  a_r3_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: bits outside the clear mask survive
  a_r8_clear_only_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> ((status_q & $past(status_q) & ~$past(wdata_i))
                 == ($past(status_q) & ~$past(wdata_i))));

  // R9: every detected event is present next cycle, clear or not
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vec != '0) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  // R11: new flags only appear on armed pins
  a_r11_unarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_any)) == '0));

  // R10: interrupt only rises after an event
  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_vec) != '0));
endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .status_q(status_q),
  .evt_vec(evt_vec), .en_any(en_any)
);

// File: tb/sim_gpio_evt_bank.sv
module sim_gpio_evt_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic [2:0]    addr_i = '0;
  logic [NP-1:0] wdata_i = '0;
  logic          we_i = 1'b0;
  logic [NP-1:0] rdata_o;
  logic          irq_o;

  gpio_evt_bank #(.NPINS(NP)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [2:0]    a;
    logic [NP-1:0] d;
    logic          irq;
    string         tag;
  } exp_t;

  exp_t  sb_q[$];
  event  mon_ev;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;

  // monitor: pops expected items and compares with the ports
  initial forever begin
    @(mon_ev);
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rdata_o !== it.d) begin
        n_err++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", it.tag, it.a, rdata_o, it.d);
      end
      n_chk++;
      if (irq_o !== it.irq) begin
        n_err++;
        $display("FAIL %s irq actual=%b expected=%b", it.tag, irq_o, it.irq);
      end
    end
  end

  task automatic chk(input logic [2:0] a, input logic [NP-1:0] d, input logic irq, input string tag);
    exp_t it;
    @(negedge clk_i);
    addr_i = a;
    #1;
    it.a = a; it.d = d; it.irq = irq; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic setp(input logic [NP-1:0] v);
    @(negedge clk_i);
    pins_i = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    pins_i = 32'h20;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    for (int a = 0; a < 5; a++) chk(3'(a), '0, 1'b0, "R1 reset");
    // R2
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd1, 32'h5A5A_F0F0);
    chk(3'd0, 32'hA5A5_0F0F, 1'b0, "R2 rise readback");
    chk(3'd1, 32'h5A5A_F0F0, 1'b0, "R2 fall readback");
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h20);
    wr(3'd0, 32'h5);
    wr(3'd1, 32'h6);
    chk(3'd2, 32'h10, 1'b0, "R2 high readback");
    chk(3'd3, 32'h20, 1'b0, "R2 low readback");
    chk(3'd0, 32'h5, 1'b0, "R2 rise rewrite");
    // R11 unmapped address
    wr(3'd5, 32'hFFFF_FFFF);
    chk(3'd5, '0, 1'b0, "R11 unmapped read");
    chk(3'd1, 32'h6, 1'b0, "R11 unmapped write no effect");
    chk(3'd4, '0, 1'b0, "R11 no spurious flag");
    // R3
    setp(32'h21);
    chk(3'd4, 32'h1, 1'b1, "R3 rise sets");
    setp(32'h20);
    chk(3'd4, 32'h1, 1'b1, "R3 flag stays after fall");
    // R4
    setp(32'h22);
    chk(3'd4, 32'h1, 1'b1, "R4 rise ignored");
    setp(32'h20);
    chk(3'd4, 32'h3, 1'b1, "R4 fall sets");
    // R5
    setp(32'h24);
    chk(3'd4, 32'h7, 1'b1, "R5 double edge rise");
    wr(3'd4, 32'h4);
    chk(3'd4, 32'h3, 1'b1, "R5 edge flag cleared");
    setp(32'h20);
    chk(3'd4, 32'h7, 1'b1, "R5 double edge fall");
    // R8 and R10
    wr(3'd4, 32'h1);
    chk(3'd4, 32'h6, 1'b1, "R8 partial clear");
    wr(3'd4, 32'h6);
    chk(3'd4, '0, 1'b0, "R10 irq low when clear");
    // R6
    setp(32'h30);
    chk(3'd4, 32'h10, 1'b1, "R6 high level sets");
    wr(3'd4, 32'h10);
    chk(3'd4, 32'h10, 1'b1, "R6 clear while high re-latches");
    setp(32'h20);
    chk(3'd4, 32'h10, 1'b1, "R6 flag held after fall");
    wr(3'd4, 32'h10);
    chk(3'd4, '0, 1'b0, "R6 clear after deassert");
    // R7
    setp(32'h00);
    chk(3'd4, 32'h20, 1'b1, "R7 low level sets");
    wr(3'd4, 32'h20);
    chk(3'd4, 32'h20, 1'b1, "R7 clear while low re-latches");
    setp(32'h20);
    wr(3'd4, 32'h20);
    chk(3'd4, '0, 1'b0, "R7 clear after deassert");
    // R11 unarmed pin
    setp(32'h120);
    setp(32'h20);
    chk(3'd4, '0, 1'b0, "R11 unarmed pin toggles");
    // R9: rise on pin 0 coincides with clear of bit 0
    @(negedge clk_i);
    pins_i = 32'h21; we_i = 1'b1; addr_i = 3'd4; wdata_i = 32'h1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk(3'd4, 32'h1, 1'b1, "R9 set beats clear");
    wr(3'd4, 32'h1);
    chk(3'd4, '0, 1'b0, "R10 irq drops");
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule